// File: doc/BRIEF.md
# QPSK Relative-Phase Decoder and Bit Serializer

This block sits after the symbol slicer of a coherent QPSK receiver. The carrier loop can lock at any of four phase positions, so the absolute quadrant of a symbol carries no information. The transmitter therefore encodes each data dibit as a phase step between consecutive symbols. This block reverses that step.

On every symbol strobe the block reduces the signed I/Q decision to a 2-bit quadrant index. It subtracts the quadrant held from the previous symbol, modulo 4, and maps the step through a Gray table to a dibit. It then sends that dibit out as two serial bits, each marked by a bit-valid strobe.

At the nominal rate of 9.856 Mbit/s the symbol rate is 4.928 Msym/s. With a system clock of a few tens of MHz this gives several clock cycles per symbol. The block only needs two cycles between symbol strobes.

Top module: `qpsk_diff_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `bitValid` is low.
- R2: The quadrant index is 0 for I≥0 and Q≥0, 1 for I<0 and Q≥0, 2 for I<0 and Q<0, and 3 for I≥0 and Q<0. A zero component counts as non-negative.
- R3: The first symbol strobe after any reset only stores its quadrant and produces no output bits.
- R4: Every later symbol produces the dibit for the step (current − previous) mod 4: step 0 gives 00, step 1 gives 01, step 2 gives 11, and step 3 gives 10.
- R5: Each decoded dibit appears as exactly two bits, with `bitValid` high in the two cycles that directly follow the strobe cycle. The dibit's MSB comes first and its LSB second.
- R6: If every input symbol is rotated by the same multiple of 90°, the output bit stream does not change.
- R7: Strobes may come as close as every second cycle. A strobe that arrives while the LSB of the previous dibit is on the output still lets that LSB through, and the next MSB follows with no gap.
- R8: `bitValid` never rises unless a decoded symbol caused it. In idle cycles no bits come out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| symValid | input | 1 | One-cycle strobe marking a new symbol decision |
| symI | input | SAMPLE_W | Signed in-phase decision value |
| symQ | input | SAMPLE_W | Signed quadrature decision value |
| bitData | output | 1 | Serial output bit |
| bitValid | output | 1 | High in each cycle that carries a valid output bit |

## Verification
Loading a new dibit into the serializer and shifting out the LSB of the previous dibit can fall in the same cycle. This happens when symbol strobes come every second cycle. The bench provokes it with a burst of strobes at that minimum spacing. The scoreboard checks every bit's value and order. The bench also measures the longest unbroken run of `bitValid` and requires it to equal twice the symbol count, so a dropped LSB or a stall would show. The same burst is replayed under all four constellation rotations, and the captured streams are compared.

// File: rtl/qpsk_dd_pkg.sv
package qpsk_dd_pkg;

  localparam int DIBIT_W = 2;

  typedef logic [1:0] quad_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic loadPrev;   // capture the current quadrant as the reference
    logic emitDibit;  // load a decoded dibit into the serializer
    logic shiftOut;   // advance the serializer by one bit
  } ctrl_strobes_t;

endpackage

// File: rtl/qpsk_dd_ctrl.sv
module qpsk_dd_ctrl
  import qpsk_dd_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          symValid,
  output ctrl_strobes_t strobes,
  output logic          bitValid
);

  localparam int CNT_W = $clog2(DIBIT_W + 1);

  logic             primed;
  logic [CNT_W-1:0] bitsLeft;

  always_comb begin
    strobes.loadPrev  = symValid;
    strobes.emitDibit = symValid & primed;
    // A new load takes priority over shifting; the old LSB is already out.
    strobes.shiftOut  = (bitsLeft != '0) & ~strobes.emitDibit;
  end

  assign bitValid = (bitsLeft != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed   <= 1'b0;
      bitsLeft <= '0;
    end else begin
      if (symValid) primed <= 1'b1;
      if (strobes.emitDibit)    bitsLeft <= CNT_W'(DIBIT_W);
      else if (bitsLeft != '0)  bitsLeft <= bitsLeft - 1'b1;
    end
  end

endmodule

// File: rtl/qpsk_dd_datapath.sv
module qpsk_dd_datapath
  import qpsk_dd_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] symI,
  input  logic signed [SAMPLE_W-1:0] symQ,
  input  ctrl_strobes_t              strobes,
  output logic                       bitData
);

  localparam logic signed [SAMPLE_W-1:0] ZERO = '0;

  logic               iNeg, qNeg;
  quad_t              curQuad, prevQuad, stepQuad;
  logic [DIBIT_W-1:0] dibit, shiftReg;

  // Quadrant slicer: the index counts up counter-clockwise.
  assign iNeg = (symI < ZERO);
  assign qNeg = (symQ < ZERO);

  always_comb begin
    unique case ({qNeg, iNeg})
      2'b00:   curQuad = 2'd0;
      2'b01:   curQuad = 2'd1;
      2'b11:   curQuad = 2'd2;
      default: curQuad = 2'd3;
    endcase
  end

  // Phase step modulo 4, then Gray-coded into a dibit.
  assign stepQuad = curQuad - prevQuad;
  assign dibit    = {stepQuad[1], stepQuad[1] ^ stepQuad[0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQuad <= '0;
      shiftReg <= '0;
    end else begin
      if (strobes.loadPrev) prevQuad <= curQuad;
      if (strobes.emitDibit)     shiftReg <= dibit;
      else if (strobes.shiftOut) shiftReg <= {shiftReg[DIBIT_W-2:0], 1'b0};
    end
  end

  assign bitData = shiftReg[DIBIT_W-1];

endmodule

// File: rtl/qpsk_diff_decoder.sv
module qpsk_diff_decoder
  import qpsk_dd_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       symValid,
  input  logic signed [SAMPLE_W-1:0] symI,
  input  logic signed [SAMPLE_W-1:0] symQ,
  output logic                       bitData,
  output logic                       bitValid
);

  ctrl_strobes_t strobes;

  qpsk_dd_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .symValid (symValid),
    .strobes  (strobes),
    .bitValid (bitValid)
  );

  qpsk_dd_datapath #(.SAMPLE_W(SAMPLE_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .symI    (symI),
    .symQ    (symQ),
    .strobes (strobes),
    .bitData (bitData)
  );

endmodule

// File: rtl/qpsk_dd_checker.sv
module qpsk_dd_checker (
  input logic clk,
  input logic rstN,
  input logic symValid,
  input logic bitValid
);

  logic seenSym;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         seenSym <= 1'b0;
    else if (symValid) seenSym <= 1'b1;
  end

  AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    symValid && !seenSym && !bitValid |=> !bitValid); // R3

  AST_DECODED_EMITS: assert property (@(posedge clk) disable iff (!rstN)
    symValid && seenSym |=> bitValid); // R5

  AST_TWO_BITS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bitValid) |=> bitValid); // R5

  AST_NO_IDLE_BITS: assert property (@(posedge clk) disable iff (!rstN)
    !symValid && !bitValid |=> !bitValid); // R8

  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    symValid |=> !symValid); // R7

endmodule

bind qpsk_diff_decoder qpsk_dd_checker u_qpsk_dd_checker (
  .clk      (clk),
  .rstN     (rstN),
  .symValid (symValid),
  .bitValid (bitValid)
);

// File: tb/test_qpsk_diff_decoder.sv
module test_qpsk_diff_decoder;

  localparam int SW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic symValid = 1'b0;
  logic signed [SW-1:0] symI = '0;
  logic signed [SW-1:0] symQ = '0;
  logic bitData, bitValid;

  always #10 clk = ~clk;  // 50 MHz

  qpsk_diff_decoder #(.SAMPLE_W(SW)) i_qpsk_diff_decoder (
    .clk(clk), .rstN(rstN), .symValid(symValid),
    .symI(symI), .symQ(symQ), .bitData(bitData), .bitValid(bitValid)
  );

  int errors = 0;
  int checks = 0;
  logic  expBit[$];
  string expTag[$];
  logic  capBits[$];
  logic  baseBits[$];
  int bitsSeen = 0;
  int runLen = 0;
  int maxRun = 0;
  logic [1:0]  tbPrev = '0;
  bit          tbPrimed = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor: samples away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (bitValid) begin
        bitsSeen++;
        capBits.push_back(bitData);
        runLen++;
        if (runLen > maxRun) maxRun = runLen;
        if (expBit.size() == 0) begin
          check(0, "R8", "unexpected bit", int'(bitData), -1);
        end else begin
          logic  e;
          string t;
          e = expBit.pop_front();
          t = expTag.pop_front();
          check(bitData === e, t, "bit value", int'(bitData), int'(e));
        end
      end else begin
        runLen = 0;
      end
    end
  end

  function automatic logic [1:0] quadOf(int i, int q);
    if (q >= 0) return (i >= 0) ? 2'd0 : 2'd1;
    return (i < 0) ? 2'd2 : 2'd3;
  endfunction

  function automatic logic [15:0] lfsrNext(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // Called at posedge+1; holds the strobe one cycle, then idles gap-1 cycles.
  task automatic driveSym(int i, int q, int gap);
    symValid = 1'b1;
    symI = SW'(i);
    symQ = SW'(q);
    @(posedge clk); #1;
    symValid = 1'b0;
    repeat (gap - 1) begin @(posedge clk); #1; end
  endtask

  task automatic driveQuad(logic [1:0] quad, int gap);
    int mi, mq;
    lfsr = lfsrNext(lfsr);
    mi = 1 + int'(lfsr[5:0]);
    mq = 1 + int'(lfsr[11:6]);
    case (quad)
      2'd0: driveSym( mi,  mq, gap);
      2'd1: driveSym(-mi,  mq, gap);
      2'd2: driveSym(-mi, -mq, gap);
      default: driveSym(mi, -mq, gap);
    endcase
  endtask

  task automatic sendRef(logic [1:0] quad, logic [1:0] rot, int gap);
    tbPrev = quad;
    tbPrimed = 1;
    driveQuad(quad + rot, gap);
  endtask

  // Absolute-to-relative encoder for the stimulus.
  task automatic sendDibit(logic [1:0] d, logic [1:0] rot, int gap, string tag);
    logic [1:0] step;
    step = {d[1], d[1] ^ d[0]};
    tbPrev = tbPrev + step;
    expBit.push_back(d[1]); expTag.push_back(tag);
    expBit.push_back(d[0]); expTag.push_back(tag);
    driveQuad(tbPrev + rot, gap);
  endtask

  task automatic sendRaw(int i, int q, int gap, string tag);
    logic [1:0] qq, step;
    qq = quadOf(i, q);
    if (tbPrimed) begin
      step = qq - tbPrev;
      expBit.push_back(step[1]);           expTag.push_back(tag);
      expBit.push_back(step[1] ^ step[0]); expTag.push_back(tag);
    end
    tbPrev = qq;
    tbPrimed = 1;
    driveSym(i, q, gap);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    symValid = 1'b0;
    tbPrimed = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(bitValid === 1'b0, "R1", "bitValid after reset", int'(bitValid), 0);
    @(posedge clk); #1;
  endtask

  task automatic drain(string tag);
    repeat (4) begin @(posedge clk); #1; end
    check(expBit.size() == 0, tag, "pending expected bits", expBit.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R5", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int snap;
    logic [1:0] seq[12];

    #5;
    check(bitValid === 1'b0, "R1", "bitValid during reset", int'(bitValid), 0);
    doReset();

    // R3: reference symbol is silent
    sendRef(2'd0, 2'd0, 4);
    check(bitsSeen == 0, "R3", "bits after first symbol", bitsSeen, 0);

    // R4: all four phase steps
    sendDibit(2'b00, 2'd0, 4, "R4");
    sendDibit(2'b01, 2'd0, 4, "R4");
    sendDibit(2'b11, 2'd0, 4, "R4");
    sendDibit(2'b10, 2'd0, 4, "R4");
    drain("R4");

    // R5: exactly two bits per symbol, MSB first
    snap = bitsSeen; maxRun = 0;
    sendDibit(2'b10, 2'd0, 6, "R5");
    drain("R5");
    check(bitsSeen - snap == 2, "R5", "bits per symbol", bitsSeen - snap, 2);
    check(maxRun == 2, "R5", "valid run length", maxRun, 2);

    // R2: axis values count as non-negative
    sendRaw(0, 0, 3, "R2");
    sendRaw(0, -3, 3, "R2");
    sendRaw(-3, 0, 3, "R2");
    sendRaw(5, 0, 3, "R2");
    sendRaw(-1, -1, 3, "R2");
    sendRaw(0, 7, 3, "R2");
    drain("R2");

    // R7: minimum spacing, load and last shift coincide
    maxRun = 0;
    for (int k = 0; k < 6; k++) sendDibit(2'(k * 3 + 1), 2'd0, 2, "R7");
    drain("R7");
    check(maxRun == 12, "R7", "gapless burst length", maxRun, 12);

    // R8: idle produces nothing
    snap = bitsSeen;
    repeat (10) begin @(posedge clk); #1; end
    check(bitsSeen == snap, "R8", "bits while idle", bitsSeen - snap, 0);

    // R3: mid-stream reset re-primes
    doReset();
    snap = bitsSeen;
    sendRef(2'd3, 2'd0, 4);
    check(bitsSeen == snap, "R3", "bits after re-primed symbol", bitsSeen - snap, 0);

    // R6: rotation invariance
    for (int k = 0; k < 12; k++) begin
      lfsr = lfsrNext(lfsr);
      seq[k] = lfsr[1:0];
    end
    for (int rot = 0; rot < 4; rot++) begin
      doReset();
      capBits.delete();
      sendRef(2'd1, 2'(rot), 3);
      for (int k = 0; k < 12; k++) sendDibit(seq[k], 2'(rot), (k % 2 == 0) ? 2 : 3, "R6");
      drain("R6");
      if (rot == 0) begin
        baseBits = capBits;
      end else begin
        check(capBits.size() == baseBits.size(), "R6", "rotated stream length",
              capBits.size(), baseBits.size());
        for (int n = 0; n < capBits.size() && n < baseBits.size(); n++)
          check(capBits[n] === baseBits[n], "R6", "rotated stream bit",
                int'(capBits[n]), int'(baseBits[n]));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule